// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and a calendar as packed BCD bytes: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. A binary prescaler counts enable pulses from a 32.768 kHz reference. With the default fifteen stages it produces one carry per second, and that carry ripples through the time and date fields in a single system-clock cycle.

The hour byte holds its own format controls. The top bit selects the 12-hour display and the next bit marks the afternoon. February's length comes from a two-bit leap counter. That counter can be overridden by a two-bit leap control field, which shares a byte with the day of week.

A host writes any byte by address and reads any byte by address with one cycle of latency. Two more inputs control timing: one freezes timekeeping and one restarts the sub-second phase. A busy output marks the cycle just before each seconds carry, so that software knows when a multi-byte read could be torn.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After synchronous reset every byte reads 00h except day of month and month, which read 01h. `busy` and `rd_data` are 0.
- R2: The seconds byte advances once per 2^DIV_STAGES clock edges that have `ref_tick` high and `clk_stop` low. Edges with `ref_tick` low do not count.
- R3: Seconds and minutes count in BCD from 00h to 59h. At 59h they wrap to 00h and carry into the next field.
- R4: With hour bit 7 clear (24-hour format) the hour counts 00h to 23h, and 23h wraps to 00h with a day carry. In this format bit 6 always reads 0, even when a write sets it.
- R5: With hour bit 7 set, bit 6 means PM and the low six bits hold 01h to 12h in BCD. 11 AM (91h) goes to 12 PM (D2h), and D2h goes to C1h. 11 PM (D1h) goes to 12 AM (92h) with a day carry, and 92h goes to 81h.
- R6: Day of week (address 3, bits 2:0) advances on each day carry and wraps from 6 to 0.
- R7: Months 04h, 06h, 09h and 11h end after day 30h, the others except February after day 31h. A carry out of month 12h gives month 01h and advances the year. Year 99h wraps to 00h.
- R8: Address 3 holds the leap control in bits 7:6 and the leap counter in bits 5:4. February ends after day 29h only when control bit 7 is 0 and the counter is 0; otherwise it ends after 28h. The counter increments modulo 4 at every month-12h-to-01h carry.
- R9: A write to address 3 replaces the leap counter only when bit 6 of the written byte is 1. Otherwise the counter keeps its value.
- R10: A write replaces only the addressed field. If it lands on a carry edge, the other fields still advance. Address 7 reads 00h and writes to it change nothing.
- R11: While `clk_stop` is high the prescaler and every field hold, and host writes still take effect.
- R12: `cnt_reset` clears the prescaler, so the next seconds carry needs a full 2^DIV_STAGES counted edges.
- R13: `busy` is high exactly while the prescaler sits at its terminal count, which is the cycle before a carry edge.
- R14: `rd_data` shows the byte selected by `rd_addr` at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per 32.768 kHz reference period |
| clk_stop | input | 1 | Freeze prescaler and counters |
| cnt_reset | input | 1 | Clear prescaler stages |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Write byte select |
| wr_data | input | 8 | Write data (BCD) |
| rd_addr | input | 3 | Read byte select |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Carry-pending indication |

## Verification
A counted edge moves the prescaler at that edge. A carry edge shows up on `rd_data` one cycle later, because the read path is registered. `busy` rises in the same cycle that the terminal count is registered. A write appears on the next read of its address.

The bench keeps a behavioural model that advances on the same edges. It compares `rd_data` and `busy` half a period after every edge. The targeted checks freeze the counters with `clk_stop` before reading a byte, so each expected constant is fixed at the moment it is sampled.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int REG_DW = 8;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] SEL_SEC  = 3'd0;
  localparam logic [REG_AW-1:0] SEL_MIN  = 3'd1;
  localparam logic [REG_AW-1:0] SEL_HOUR = 3'd2;
  localparam logic [REG_AW-1:0] SEL_WEEK = 3'd3;
  localparam logic [REG_AW-1:0] SEL_DAY  = 3'd4;
  localparam logic [REG_AW-1:0] SEL_MON  = 3'd5;
  localparam logic [REG_AW-1:0] SEL_YEAR = 3'd6;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic       h12;
    logic       pm;
    logic [5:0] hour;
    logic [1:0] lctl;
    logic [1:0] lcnt;
    logic [2:0] dow;
    logic [5:0] day;
    logic [4:0] mon;
    logic [7:0] yr;
  } cal_state_t;

  localparam cal_state_t CAL_RESET = '{sec: 7'h00, min: 7'h00, h12: 1'b0, pm: 1'b0,
                                       hour: 6'h00, lctl: 2'b00, lcnt: 2'b00, dow: 3'd0,
                                       day: 6'h01, mon: 5'h01, yr: 8'h00};

  // two-digit BCD increment (caller handles wrap)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] month_last_day(input logic [4:0] mon, input logic feb29);
    case (mon)
      5'h02:                      month_last_day = feb29 ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_last_day = 6'h30;
      default:                    month_last_day = 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int STAGES = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic stop,
  input  logic clr,
  output logic tick,
  output logic busy
);
  localparam logic [STAGES-1:0] TOP = '1;
  localparam logic [STAGES-1:0] ONE = STAGES'(1);

  logic [STAGES-1:0] cnt, cnt_nxt;
  logic              adv;

  assign adv  = ref_tick && !stop && !clr;
  assign tick = adv && (cnt == TOP);

  always_comb begin
    cnt_nxt = cnt;
    if (clr)      cnt_nxt = '0;
    else if (adv) cnt_nxt = cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      busy <= (cnt_nxt == TOP);
    end
  end

  // R13: a carry is only issued while busy is showing
  assert_busy_before_carry_R13: assert property (@(posedge clk) disable iff (rst)
    tick |-> busy);
  // R11: a stopped prescaler holds its phase
  assert_stop_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (stop && !clr) |=> $stable(cnt));
  // R12: clearing restarts the phase at zero
  assert_clear_phase_R12: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0) && !busy);
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data
);
  cal_state_t cur, adv, nxt;
  logic c_min, c_hr, c_day, c_mon;
  logic feb29;
  logic [5:0] last_day;

  always_comb begin
    adv      = cur;
    c_min    = 1'b0;
    c_hr     = 1'b0;
    c_day    = 1'b0;
    c_mon    = 1'b0;
    feb29    = !cur.lctl[1] && (cur.lcnt == 2'd0);
    last_day = month_last_day(cur.mon, feb29);
    if (sec_tick) begin
      if (cur.sec >= 7'h59) begin adv.sec = 7'h00; c_min = 1'b1; end
      else adv.sec = 7'(bcd_inc({1'b0, cur.sec}));
    end
    if (c_min) begin
      if (cur.min >= 7'h59) begin adv.min = 7'h00; c_hr = 1'b1; end
      else adv.min = 7'(bcd_inc({1'b0, cur.min}));
    end
    if (c_hr) begin
      if (!cur.h12) begin
        if (cur.hour >= 6'h23) begin adv.hour = 6'h00; c_day = 1'b1; end
        else adv.hour = 6'(bcd_inc({2'b00, cur.hour}));
      end else if (cur.hour == 6'h12) begin
        adv.hour = 6'h01;
      end else if (cur.hour == 6'h11) begin
        adv.hour = 6'h12;
        adv.pm   = !cur.pm;
        c_day    = cur.pm;
      end else begin
        adv.hour = 6'(bcd_inc({2'b00, cur.hour}));
      end
    end
    if (c_day) begin
      adv.dow = (cur.dow >= 3'd6) ? 3'd0 : cur.dow + 3'd1;
      if (cur.day >= last_day) begin adv.day = 6'h01; c_mon = 1'b1; end
      else adv.day = 6'(bcd_inc({2'b00, cur.day}));
    end
    if (c_mon) begin
      if (cur.mon >= 5'h12) begin
        adv.mon  = 5'h01;
        adv.lcnt = cur.lcnt + 2'd1;
        adv.yr   = (cur.yr >= 8'h99) ? 8'h00 : bcd_inc(cur.yr);
      end else begin
        adv.mon = 5'(bcd_inc({3'b000, cur.mon}));
      end
    end
  end

  // host write overrides only the addressed field of the advanced state
  always_comb begin
    nxt = adv;
    if (wr_en) begin
      case (wr_addr)
        SEL_SEC:  nxt.sec = wr_data[6:0];
        SEL_MIN:  nxt.min = wr_data[6:0];
        SEL_HOUR: begin
          nxt.h12  = wr_data[7];
          nxt.pm   = wr_data[7] & wr_data[6];
          nxt.hour = wr_data[5:0];
        end
        SEL_WEEK: begin
          nxt.lctl = wr_data[7:6];
          if (wr_data[6]) nxt.lcnt = wr_data[5:4];
          nxt.dow  = wr_data[2:0];
        end
        SEL_DAY:  nxt.day = wr_data[5:0];
        SEL_MON:  nxt.mon = wr_data[4:0];
        SEL_YEAR: nxt.yr  = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= CAL_RESET;
      rd_data <= '0;
    end else begin
      cur <= nxt;
      case (rd_addr)
        SEL_SEC:  rd_data <= {1'b0, cur.sec};
        SEL_MIN:  rd_data <= {1'b0, cur.min};
        SEL_HOUR: rd_data <= {cur.h12, cur.pm, cur.hour};
        SEL_WEEK: rd_data <= {cur.lctl, cur.lcnt, 1'b0, cur.dow};
        SEL_DAY:  rd_data <= {2'b00, cur.day};
        SEL_MON:  rd_data <= {3'b000, cur.mon};
        SEL_YEAR: rd_data <= cur.yr;
        default:  rd_data <= '0;
      endcase
    end
  end

  // R11: without a carry or a write nothing moves
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !wr_en) |=> (cur == $past(cur)));
  // R3: seconds wrap at 59
  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_en && cur.sec == 7'h59) |=> (cur.sec == 7'h00));
  // R4: no PM flag in 24-hour format
  assert_pm_clear_24h_R4: assert property (@(posedge clk) disable iff (rst)
    !cur.h12 |-> !cur.pm);
  // R9: protected leap counter survives a write
  assert_leap_protect_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SEL_WEEK && !wr_data[6] && !sec_tick) |=> (cur.lcnt == $past(cur.lcnt)));
  // R6: weekday wraps from 6
  assert_dow_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (c_day && !wr_en && cur.dow == 3'd6) |=> (cur.dow == 3'd0));
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int DIV_STAGES = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       clk_stop,
  input  logic       cnt_reset,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy
);
  logic sec_tick;

  cal_prescaler #(.STAGES(DIV_STAGES)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .ref_tick(ref_tick),
    .stop    (clk_stop),
    .clr     (cnt_reset),
    .tick    (sec_tick),
    .busy    (busy)
  );

  cal_timekeeper u_keep (
    .clk     (clk),
    .rst     (rst),
    .sec_tick(sec_tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: tb/tb_bcd_calendar_clock.sv
module tb_bcd_calendar_clock;
  localparam int DIV  = 3;
  localparam int TOPM = (1 << DIV) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b1, clk_stop = 1'b1, cnt_reset = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0, rd_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic busy;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  bcd_calendar_clock #(.DIV_STAGES(DIV)) dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .clk_stop(clk_stop), .cnt_reset(cnt_reset),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  // behavioural reference model, integers in decimal
  int m_pre, m_sec, m_min, m_h24, m_dow, m_lctl, m_lcnt, m_day, m_mon, m_yr;
  bit m_12;
  logic [7:0] exp_rd = 8'h00;
  logic exp_busy = 1'b0;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int unbcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int month_len();
    if (m_mon == 2) return (m_lctl < 2 && m_lcnt == 0) ? 29 : 28;
    if (m_mon == 4 || m_mon == 6 || m_mon == 9 || m_mon == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] encode(input logic [2:0] a);
    int h;
    case (a)
      3'd0: return bcd(m_sec);
      3'd1: return bcd(m_min);
      3'd2: begin
        if (!m_12) return bcd(m_h24);
        h = m_h24 % 12;
        if (h == 0) h = 12;
        return 8'h80 | ((m_h24 >= 12) ? 8'h40 : 8'h00) | bcd(h);
      end
      3'd3: return 8'((m_lctl << 6) | (m_lcnt << 4) | m_dow);
      3'd4: return bcd(m_day);
      3'd5: return bcd(m_mon);
      3'd6: return bcd(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_second();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_h24++;
        if (m_h24 == 24) begin
          m_h24 = 0;
          m_dow = (m_dow + 1) % 7;
          if (m_day >= month_len()) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_lcnt = (m_lcnt + 1) % 4; m_yr = (m_yr + 1) % 100;
            end
          end else m_day++;
        end
      end
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    int h;
    case (a)
      3'd0: m_sec = unbcd({1'b0, d[6:0]});
      3'd1: m_min = unbcd({1'b0, d[6:0]});
      3'd2: begin
        m_12 = d[7];
        h = unbcd({2'b00, d[5:0]});
        m_h24 = m_12 ? (h % 12) + (d[6] ? 12 : 0) : h;
      end
      3'd3: begin
        m_lctl = int'(d[7:6]);
        if (d[6]) m_lcnt = int'(d[5:4]);
        m_dow = int'(d[2:0]);
      end
      3'd4: m_day = unbcd({2'b00, d[5:0]});
      3'd5: m_mon = unbcd({3'b000, d[4:0]});
      3'd6: m_yr  = unbcd(d);
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_sec = 0; m_min = 0; m_h24 = 0; m_12 = 0; m_dow = 0;
      m_lctl = 0; m_lcnt = 0; m_day = 1; m_mon = 1; m_yr = 0;
      exp_rd = 8'h00; exp_busy = 1'b0;
    end else begin
      exp_rd = encode(rd_addr);
      if (cnt_reset) m_pre = 0;
      else if (ref_tick && !clk_stop) begin
        if (m_pre == TOPM) begin m_pre = 0; model_second(); end
        else m_pre++;
      end
      if (wr_en) model_write(wr_addr, wr_data);
      exp_busy = (m_pre == TOPM);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rd_data !== exp_rd || busy !== exp_busy) begin
        failures++;
        $display("FAIL %s: per-cycle rd_data=%02h busy=%0b expected rd_data=%02h busy=%0b",
                 cur_req, rd_data, busy, exp_rd, exp_busy);
      end
    end
  end

  task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: %s got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, input logic [7:0] e, input string req);
    @(negedge clk) rd_addr = a;
    @(negedge clk);
    check8(req, $sformatf("byte %0d", a), rd_data, e);
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic phase_clear();
    @(negedge clk) cnt_reset = 1'b1;
    @(negedge clk) cnt_reset = 1'b0;
  endtask

  task automatic go(input int n);
    @(negedge clk) clk_stop = 1'b0;
    repeat (n) begin
      rd_addr = (rd_addr == 3'd6) ? 3'd0 : rd_addr + 3'd1;
      @(negedge clk);
    end
    clk_stop = 1'b1;
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    host_write(3'd2, h);
    host_write(3'd1, m);
    host_write(3'd0, s);
  endtask

  task automatic one_second();
    phase_clear();
    go(1 << DIV);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset contents
    cur_req = "R1";
    peek(3'd0, 8'h00, "R1");
    peek(3'd2, 8'h00, "R1");
    peek(3'd3, 8'h00, "R1");
    peek(3'd4, 8'h01, "R1");
    peek(3'd5, 8'h01, "R1");
    peek(3'd6, 8'h00, "R1");
    check8("R1", "busy after reset", {7'd0, busy}, 8'h00);

    // R2 second rate, with and without gaps in ref_tick
    cur_req = "R2";
    phase_clear();
    go(3 << DIV);
    peek(3'd0, 8'h03, "R2");
    phase_clear();
    @(negedge clk) begin clk_stop = 1'b0; ref_tick = 1'b0; end
    repeat (8) begin
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
    end
    clk_stop = 1'b1;
    ref_tick = 1'b1;
    peek(3'd0, 8'h04, "R2");

    // R3 R4 R6 R7 R8 full rollover at end of year 99
    cur_req = "R3";
    set_hms(8'h23, 8'h59, 8'h58);
    host_write(3'd3, 8'h76);
    host_write(3'd4, 8'h31);
    host_write(3'd5, 8'h12);
    host_write(3'd6, 8'h99);
    phase_clear();
    go(2 << DIV);
    peek(3'd0, 8'h00, "R3");
    peek(3'd1, 8'h00, "R3");
    peek(3'd2, 8'h00, "R4");
    peek(3'd3, 8'h40, "R6 R8");
    peek(3'd4, 8'h01, "R7");
    peek(3'd5, 8'h01, "R7");
    peek(3'd6, 8'h00, "R7");
    cur_req = "R4";
    host_write(3'd2, 8'h55);
    peek(3'd2, 8'h15, "R4");

    // R5 12-hour sequence
    cur_req = "R5";
    set_hms(8'h91, 8'h59, 8'h59);
    one_second();
    peek(3'd2, 8'hD2, "R5");
    set_hms(8'hD2, 8'h59, 8'h59);
    one_second();
    peek(3'd2, 8'hC1, "R5");
    set_hms(8'hD1, 8'h59, 8'h59);
    one_second();
    peek(3'd2, 8'h92, "R5");
    peek(3'd3, 8'h41, "R6");
    peek(3'd4, 8'h02, "R5");
    set_hms(8'h92, 8'h59, 8'h59);
    one_second();
    peek(3'd2, 8'h81, "R5");

    // R8 February handling
    cur_req = "R8";
    host_write(3'd3, 8'h00);
    host_write(3'd5, 8'h02);
    host_write(3'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59);
    one_second();
    peek(3'd4, 8'h29, "R8");
    set_hms(8'h23, 8'h59, 8'h59);
    one_second();
    peek(3'd4, 8'h01, "R8");
    peek(3'd5, 8'h03, "R8");
    host_write(3'd3, 8'h80);
    host_write(3'd5, 8'h02);
    host_write(3'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59);
    one_second();
    peek(3'd5, 8'h03, "R8");
    host_write(3'd3, 8'h50);
    host_write(3'd5, 8'h02);
    host_write(3'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59);
    one_second();
    peek(3'd5, 8'h03, "R8");

    // R7 thirty-day month
    cur_req = "R7";
    host_write(3'd5, 8'h04);
    host_write(3'd4, 8'h30);
    set_hms(8'h23, 8'h59, 8'h59);
    one_second();
    peek(3'd5, 8'h05, "R7");
    peek(3'd4, 8'h01, "R7");

    // R9 leap counter write protection
    cur_req = "R9";
    host_write(3'd3, 8'h23);
    peek(3'd3, 8'h13, "R9");
    host_write(3'd3, 8'h63);
    peek(3'd3, 8'h63, "R9");

    // R10 address 7 and write on a carry edge
    cur_req = "R10";
    host_write(3'd7, 8'hFF);
    peek(3'd7, 8'h00, "R10");
    peek(3'd0, 8'h00, "R10");
    host_write(3'd0, 8'h59);
    host_write(3'd1, 8'h10);
    phase_clear();
    @(negedge clk) clk_stop = 1'b0;
    repeat (TOPM) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
    @(negedge clk) begin wr_en = 1'b0; clk_stop = 1'b1; end
    peek(3'd1, 8'h33, "R10");
    peek(3'd0, 8'h00, "R10");

    // R11 frozen while stopped
    cur_req = "R11";
    repeat (20) @(negedge clk);
    peek(3'd0, 8'h00, "R11");

    // R12 R13 phase clear and busy timing
    cur_req = "R12";
    go(5);
    phase_clear();
    go(TOPM);
    check8("R13", "busy at terminal count", {7'd0, busy}, 8'h01);
    peek(3'd0, 8'h00, "R12");
    go(1);
    check8("R13", "busy after carry", {7'd0, busy}, 8'h00);
    peek(3'd0, 8'h01, "R12 R14");

    finish_run();
  end
endmodule